// File: doc/BRIEF.md
# Charge-Discharge Measurement Sequencer

This block is the digital sequencer for a capacitor-based time-to-voltage measurement of short pulses, such as the phase-error pulses of a clock synthesizer. A measurement has two phases. During the first, the external charge switch is closed for the high half of the slow, jitter-free reference. During the second, the discharge switch follows the narrow pulse under measurement. The discharge phase runs until an external hysteresis comparator reports that the capacitor is back at its base voltage. The number of reference cycles that the discharge took is the measurement result. Software or a test controller converts it to a time outside this block, using the known current ratio and the reference period.

The controller runs on a fast system clock. The reference and the comparator output are asynchronous to it and each passes through its own synchroniser. A start request may arrive in any phase. It abandons any run in progress, clears the counter and opens a new charge phase. When a run ends, the count is held at the result port until the next start. A one-cycle done pulse marks the moment the result is latched. The count saturates rather than wrapping, and a flag reports the saturation.

Top module: `cdm_sequencer`

## Requirements
- R1: After reset, charge_en, discharge_en, busy, done and overflow are low and result is zero.
- R2: A start_req sampled high in any phase enters the charge phase. From the next cycle, busy is high, result and overflow are zero, and the internal count is zero. A run abandoned this way produces no done pulse.
- R3: In the charge phase, charge_en follows the synchronised reference level. It is never high in the discharge or idle phase, including the reference high half-cycle whose rising edge starts the discharge phase. It is never high together with discharge_en.
- R4: The charge phase ends at the first synchronised rising edge of the reference that follows, or coincides with, a low level of the synchronised comparator in that charge phase. A comparator low reading does not stop charge_en within the current high half-cycle.
- R5: discharge_en equals jitter_pulse during the discharge phase and is low in every other phase, whatever jitter_pulse does.
- R6: During the discharge phase, the count increments once on every synchronised reference rising edge after the one that opened the phase. The opening edge itself is not counted.
- R7: The count is 4 bits wide (CNT_W). A rising edge that arrives when the count is already at 15 leaves it at 15 and sets overflow. overflow stays set until the next start.
- R8: A synchronised comparator high level during the discharge phase ends the run. On the same clock edge, the count is copied to result, done goes high for exactly one cycle, and the block returns to idle with busy low. Termination takes precedence over a coincident reference edge.
- R9: Outside a start or a termination, result does not change. In the idle phase, the reference, jitter_pulse and cmp_out have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the reference |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk_in | input | 1 | Slow jitter-free reference, asynchronous |
| start_req | input | 1 | Begin a new measurement (one system cycle) |
| jitter_pulse | input | 1 | Pulse under measurement |
| cmp_out | input | 1 | Hysteresis comparator output, high while at base level, asynchronous |
| charge_en | output | 1 | Closes the charging current switch |
| discharge_en | output | 1 | Closes the discharging current switch |
| busy | output | 1 | High while charging or discharging |
| done | output | 1 | One-cycle pulse when result is latched |
| result | output | CNT_W | Latched discharge cycle count |
| overflow | output | 1 | Count saturated during the current or last run |

## Verification
The assertions check several rules on every cycle. Charge and discharge enables are never high together. discharge_en is never high without the pulse input. The count never wraps, and saturation sets the flag. Every start lands in the charge phase. A comparator high level in the discharge phase always produces a single done pulse and idle on the next edge. Outside a start or a termination, the result register holds its value. Only the bench scenarios can show the end-to-end behaviour: that the latched count equals the number of reference edges seen after the opening one, that charging survives a mid-half-cycle comparator flip, that a restart abandons a run without a done pulse, and that the inputs are ignored while idle.

// File: rtl/cdm_pkg.sv
// Shared definitions for the charge-discharge measurement sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package cdm_pkg;

    // Measurement phase encoding
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CHARGE = 2'd1,
        PH_DISCH  = 2'd2
    } phase_t;

endpackage

// File: rtl/cdm_sync.sv
// Multi-stage flop synchroniser for one asynchronous level.
// Assumes: input changes slower than the clock; reset value chosen per use.
module cdm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the level one stage along the chain
            always_ff @(posedge clk) begin
                if (!rst_n)
                    chain[i] <= RST_VAL;
                else if (i == 0)
                    chain[i] <= din;
                else
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];

endmodule

// File: rtl/cdm_sat_counter.sv
// Saturating up-counter with a sticky saturation flag.
// Assumes: clr has priority over inc; flag clears only on clr or reset.
module cdm_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] value,
    output logic             sat_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic at_max;
    assign at_max = (value == CNT_MAX);

    // Count value: clear, step, or hold at the top
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            value <= '0;
        else if (inc && !at_max)
            value <= value + 1'b1;
    end

    // Sticky flag raised by a step attempted at the top value
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            sat_flag <= 1'b0;
        else if (inc && at_max)
            sat_flag <= 1'b1;
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && !clr) |=> (value == CNT_MAX)); // R7
    AST_SAT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (at_max && inc && !clr) |=> sat_flag); // R7
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr) |=> $stable(value)); // R6
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0 && !sat_flag)); // R2

endmodule

// File: rtl/cdm_phase_fsm.sv
// Phase controller: idle, charge for reference high halves, discharge gated
// by the pulse under measurement, terminate on comparator return.
// Assumes: ref_rise is a one-cycle strobe, ref_lvl is the reference level one
// cycle behind the strobe, cmp_hi is already synchronised.
module cdm_phase_fsm
    import cdm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ref_rise,
    input  logic ref_lvl,
    input  logic cmp_hi,
    input  logic jitter,
    output logic charge_en,
    output logic discharge_en,
    output logic busy,
    output logic cnt_inc,
    output logic finish,
    output logic done
);
    phase_t phase;
    logic   armed;
    logic   leave_charge;

    assign leave_charge = (phase == PH_CHARGE) && ref_rise && (armed || !cmp_hi);
    assign finish       = (phase == PH_DISCH) && cmp_hi && !start;
    assign cnt_inc      = (phase == PH_DISCH) && ref_rise && !cmp_hi && !start;

    // Phase register: start wins, then termination, then charge exit
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase <= PH_IDLE;
        else if (start)
            phase <= PH_CHARGE;
        else if (finish)
            phase <= PH_IDLE;
        else if (leave_charge)
            phase <= PH_DISCH;
    end

    // Remember a comparator low reading seen during this charge phase
    always_ff @(posedge clk) begin
        if (!rst_n || start)
            armed <= 1'b0;
        else if (phase == PH_CHARGE && !cmp_hi)
            armed <= 1'b1;
    end

    // One-cycle completion strobe
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else
            done <= finish;
    end

    // Switch controls derived from the phase
    always_comb begin
        charge_en    = (phase == PH_CHARGE) && ref_lvl;
        discharge_en = (phase == PH_DISCH) && jitter;
        busy         = (phase != PH_IDLE);
    end

    AST_START_CHARGE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (phase == PH_CHARGE)); // R2
    AST_ENTER_DISCH: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CHARGE && !start && ref_rise && !cmp_hi) |=> (phase == PH_DISCH)); // R4
    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DISCH && cmp_hi && !start) |=> (phase == PH_IDLE && done)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

endmodule

// File: rtl/cdm_sequencer.sv
// Top of the charge-discharge measurement sequencer. Synchronises the
// reference and comparator, detects reference rising edges, runs the phase
// controller and the saturating counter, and latches the result.
// Assumes: reference period spans many system clocks; comparator idles high.
module cdm_sequencer #(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk_in,
    input  logic             start_req,
    input  logic             jitter_pulse,
    input  logic             cmp_out,
    output logic             charge_en,
    output logic             discharge_en,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] result,
    output logic             overflow
);
    logic             ref_s;
    logic             ref_d;
    logic             ref_rise;
    logic             cmp_s;
    logic             cnt_inc;
    logic             finish;
    logic [CNT_W-1:0] count;

    cdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_ref_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_clk_in),
        .dout (ref_s)
    );

    cdm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cmp_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (cmp_out),
        .dout (cmp_s)
    );

    // Delay the synchronised reference by one cycle for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            ref_d <= 1'b0;
        else
            ref_d <= ref_s;
    end

    assign ref_rise = ref_s && !ref_d;

    cdm_phase_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_req),
        .ref_rise    (ref_rise),
        .ref_lvl     (ref_d),
        .cmp_hi      (cmp_s),
        .jitter      (jitter_pulse),
        .charge_en   (charge_en),
        .discharge_en(discharge_en),
        .busy        (busy),
        .cnt_inc     (cnt_inc),
        .finish      (finish),
        .done        (done)
    );

    cdm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_req),
        .inc     (cnt_inc),
        .value   (count),
        .sat_flag(overflow)
    );

    // Result register: cleared by start, loaded at termination
    always_ff @(posedge clk) begin
        if (!rst_n || start_req)
            result <= '0;
        else if (finish)
            result <= count;
    end

    AST_SWITCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(charge_en && discharge_en)); // R3
    AST_DIS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        discharge_en |-> jitter_pulse); // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_req && !finish) |=> $stable(result)); // R9

endmodule

// File: tb/cdm_sequencer_bench.sv
// Directed bench for cdm_sequencer: one task per scenario.
module cdm_sequencer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_clk_in = 1'b0;
    logic       start_req = 1'b0;
    logic       jitter_pulse = 1'b0;
    logic       cmp_out = 1'b1;
    logic       charge_en, discharge_en, busy, done, overflow;
    logic [3:0] result;

    int checks = 0;
    int fails = 0;
    int done_seen = 0;
    int cyc = 0;
    bit summary_done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    cdm_sequencer u_cdm_sequencer (
        .clk(clk), .rst_n(rst_n), .ref_clk_in(ref_clk_in), .start_req(start_req),
        .jitter_pulse(jitter_pulse), .cmp_out(cmp_out), .charge_en(charge_en),
        .discharge_en(discharge_en), .busy(busy), .done(done),
        .result(result), .overflow(overflow)
    );

    // Count cycles with done high
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (done) done_seen <= done_seen + 1;
    end

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // Watchdog
    always @(posedge clk) begin
        if (cyc == 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            finish_run();
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        start_req = 1'b1;
        tick(1);
        start_req = 1'b0;
    endtask

    // Start, run the charge phase, and enter discharge (opening edge not counted)
    task automatic charge_and_enter();
        pulse_start();
        tick(4);
        check("R2 busy after start", busy, 1);
        check("R2 result cleared", result, 0);
        check("R2 overflow cleared", overflow, 0);
        check("R3 charge_en low while ref low", charge_en, 0);
        ref_clk_in = 1'b1;
        tick(5);
        check("R3 charge_en follows ref high", charge_en, 1);
        jitter_pulse = 1'b1;
        tick(1);
        check("R5 pulse ignored in charge", discharge_en, 0);
        jitter_pulse = 1'b0;
        cmp_out = 1'b0;        // threshold crossed mid half-cycle
        tick(3);
        check("R4 charging holds after comparator low", charge_en, 1);
        ref_clk_in = 1'b0;
        tick(6);
        check("R3 charge_en drops with ref", charge_en, 0);
        ref_clk_in = 1'b1;     // opening edge of discharge
        tick(2);
        check("R3 no charge on opening half-cycle", charge_en, 0);
        tick(4);
        check("R4 in discharge charge_en low", charge_en, 0);
        check("R4 busy in discharge", busy, 1);
        jitter_pulse = 1'b1;
        tick(1);
        check("R5 discharge_en follows pulse", discharge_en, 1);
        jitter_pulse = 1'b0;
        tick(1);
        check("R5 discharge_en falls with pulse", discharge_en, 0);
        ref_clk_in = 1'b0;
        tick(6);
    endtask

    task automatic ref_cycles(input int k);
        for (int i = 0; i < k; i++) begin
            ref_clk_in = 1'b1;
            tick(6);
            ref_clk_in = 1'b0;
            tick(6);
        end
    endtask

    // Full measurement of k counted reference cycles
    task automatic t_measure(input int k);
        int exp_cnt;
        exp_cnt = (k > 15) ? 15 : k;
        done_seen = 0;
        charge_and_enter();
        ref_cycles(k);
        check("R8 no done before comparator", done_seen, 0);
        cmp_out = 1'b1;
        tick(6);
        check("R8 single done pulse", done_seen, 1);
        check("R8 busy low after end", busy, 0);
        check("R6 R7 result equals counted edges", result, exp_cnt);
        check("R7 overflow flag", overflow, (k > 15) ? 1 : 0);
    endtask

    task automatic t_reset();
        tick(3);
        check("R1 charge_en", charge_en, 0);
        check("R1 discharge_en", discharge_en, 0);
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        check("R1 result", result, 0);
        check("R1 overflow", overflow, 0);
    endtask

    // Restart in mid-discharge abandons the run without done
    task automatic t_restart();
        done_seen = 0;
        charge_and_enter();
        ref_cycles(2);
        pulse_start();
        tick(4);
        check("R2 restart busy", busy, 1);
        check("R2 restart result zero", result, 0);
        cmp_out = 1'b1;
        tick(6);
        check("R2 abandoned run gives no done", done_seen, 0);
        check("R2 still busy in new charge", busy, 1);
    endtask

    // Inputs toggled while idle change nothing
    task automatic t_idle_ignore(input int held);
        done_seen = 0;
        jitter_pulse = 1'b1;
        ref_clk_in = 1'b1;
        tick(6);
        check("R9 idle charge_en", charge_en, 0);
        check("R9 idle discharge_en", discharge_en, 0);
        cmp_out = 1'b0;
        ref_clk_in = 1'b0;
        tick(6);
        ref_clk_in = 1'b1;
        tick(6);
        cmp_out = 1'b1;
        jitter_pulse = 1'b0;
        ref_clk_in = 1'b0;
        tick(6);
        check("R9 idle result held", result, held);
        check("R9 idle no done", done_seen, 0);
        check("R9 idle busy", busy, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        t_measure(5);
        t_idle_ignore(5);
        t_measure(0);
        t_measure(20);
        t_restart();
        t_measure(15);
        t_measure(3);
        finish_run();
    end

endmodule